// File: doc/BRIEF.md
# Control Transfer Resolver

This block settles every control-transfer instruction of a 32-bit in-order core with one branch delay slot. The pipeline gives it the fetched instruction word, the address of that instruction and the two source operand values read for it, together with a one-cycle strobe. In the same cycle the block reports four things:
- whether the transfer is taken;
- the destination address;
- whether a return address must be written to the link register, and what that address is;
- whether the instruction is an undefined form of the sub-coded branch group.

A taken transfer tells the pipeline to let the instruction after the transfer complete, then redirect fetch to the destination. The block does not fetch, does not own the register file and does not stall anything. It only decides.

When no strobe is present, the outputs show a registered copy of the last strobed result. A consumer that samples one cycle late therefore sees stable values.

Top module: `branch_resolve`

## Requirements
- R1: After reset, and before any strobe, taken, target, link_we, link_data, link_reg and trap are all zero.
- R2: The opcode is instr[31:26]. Opcode 2 (plain jump) and opcode 3 (jump and link) are always taken. Their target is pc[31:28] followed by instr[25:0] and two zero bits.
- R3: For opcodes 1, 4, 5, 6 and 7 with a defined sub-code, target is pc + 4 + (sign-extended instr[15:0] shifted left by 2). This holds whether or not the branch is taken.
- R4: Opcode 4 is taken when rs_val equals rt_val in all 32 bits. Opcode 5 is taken when they differ.
- R5: Opcode 7 is taken when rs_val[31] is 0 and rs_val is nonzero. Opcode 6 is taken when rs_val[31] is 1 or rs_val is zero.
- R6: Opcode 1 uses the sub-code in instr[20:16]:
  - 0x00 and 0x10 are taken when rs_val[31] is 1.
  - 0x01 and 0x11 are taken when rs_val[31] is 0.
- R7: Opcode 3, and opcode 1 with sub-code 0x10 or 0x11, set link_we to 1 with link_reg = 31 and link_data = pc + 8. For the sub-coded branches this happens whether or not the branch is taken. Every other instruction gives link_we = 0 and link_reg = 0.
- R8: Opcode 1 with any other sub-code sets trap to 1, taken to 0 and link_we to 0. The target is then pc + 4.
- R9: Any opcode other than 1 to 7 gives taken = 0, trap = 0, link_we = 0 and target = pc + 4.
- R10: While in_valid is 1 the outputs reflect the current inputs in the same cycle. While in_valid is 0 they hold the result of the last strobed cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe: inputs hold an instruction to resolve |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| rs_val | input | 32 | First source operand value |
| rt_val | input | 32 | Second source operand value |
| taken | output | 1 | Transfer taken; the delay slot completes before the redirect |
| target | output | 32 | Destination address |
| link_we | output | 1 | Link register write enable |
| link_reg | output | 5 | Link register index (31 when writing) |
| link_data | output | 32 | Return address written on link |
| trap | output | 1 | Undefined sub-coded branch |

## Verification
A linking sub-coded branch can require a link write in the same cycle that its condition fails. The block must then write the link while leaving taken low. The bench drives sub-codes 0x10 and 0x11 with operands of both signs, so each sub-code is seen taken and not taken. It checks link_we and taken separately against the reference model. It also places undefined sub-codes next to defined ones, so a trap that leaks into linking or taking shows up.

// File: rtl/br_pkg.sv
package br_pkg;
    localparam int XLEN     = 32;
    localparam int OP_W     = 6;
    localparam int SUB_W    = 5;
    localparam int IDX_W    = 26;
    localparam int OFF_W    = 16;
    localparam int REG_W    = 5;
    localparam logic [REG_W-1:0] LINK_REG = 5'd31;

    typedef enum logic [3:0] {
        K_NONE, K_J, K_JAL, K_BEQ, K_BNE, K_BLEZ, K_BGTZ,
        K_BLTZ, K_BGEZ, K_BLTZAL, K_BGEZAL, K_BAD
    } ctl_kind_e;

    typedef struct packed {
        logic              taken;
        logic [XLEN-1:0]   target;
        logic              link_we;
        logic [REG_W-1:0]  link_reg;
        logic [XLEN-1:0]   link_data;
        logic              trap;
    } res_t;
endpackage

// File: rtl/br_decode.sv
module br_decode
    import br_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    input  logic [SUB_W-1:0] sub,
    output ctl_kind_e        kind
);
    always_comb begin
        kind = K_NONE;
        unique case (op)
            6'd1: begin
                unique case (sub)
                    5'h00:   kind = K_BLTZ;
                    5'h01:   kind = K_BGEZ;
                    5'h10:   kind = K_BLTZAL;
                    5'h11:   kind = K_BGEZAL;
                    default: kind = K_BAD;
                endcase
            end
            6'd2:    kind = K_J;
            6'd3:    kind = K_JAL;
            6'd4:    kind = K_BEQ;
            6'd5:    kind = K_BNE;
            6'd6:    kind = K_BLEZ;
            6'd7:    kind = K_BGTZ;
            default: kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/br_cond.sv
module br_cond
    import br_pkg::*;
#(
    parameter int W = XLEN
) (
    input  ctl_kind_e    kind,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         hit
);
    logic neg, zero, same;

    always_comb begin
        neg  = a[W-1];
        zero = (a == '0);
        same = (a == b);
        unique case (kind)
            K_BEQ:             hit = same;
            K_BNE:             hit = !same;
            K_BLEZ:            hit = neg || zero;
            K_BGTZ:            hit = !neg && !zero;
            K_BLTZ, K_BLTZAL:  hit = neg;
            K_BGEZ, K_BGEZAL:  hit = !neg;
            K_J, K_JAL:        hit = 1'b1;
            default:           hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/br_target.sv
module br_target
    import br_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int IW    = IDX_W,
    parameter int OW    = OFF_W
) (
    input  logic [W-1:0]  pc,
    input  logic [IW-1:0] idx,
    input  logic [OW-1:0] off,
    output logic [W-1:0]  jump_tgt,
    output logic [W-1:0]  branch_tgt,
    output logic [W-1:0]  seq_pc,
    output logic [W-1:0]  ret_pc
);
    localparam int REGION_W = W - IW - 2;
    localparam int EXT_W    = W - OW - 2;

    logic [W-1:0] disp;

    generate
        if (REGION_W > 0) begin : g_region
            assign jump_tgt = {pc[W-1 -: REGION_W], idx, 2'b00};
        end else begin : g_flat
            assign jump_tgt = {idx[W-3:0], 2'b00};
        end
    endgenerate

    assign disp       = {{EXT_W{off[OW-1]}}, off, 2'b00};
    assign seq_pc     = pc + W'(4);
    assign ret_pc     = pc + W'(8);
    assign branch_tgt = seq_pc + disp;
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
    import br_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] instr,
    input  logic [31:0] pc,
    input  logic [31:0] rs_val,
    input  logic [31:0] rt_val,
    output logic        taken,
    output logic [31:0] target,
    output logic        link_we,
    output logic [4:0]  link_reg,
    output logic [31:0] link_data,
    output logic        trap
);
    ctl_kind_e       kind;
    logic            hit;
    logic [XLEN-1:0] jump_tgt, branch_tgt, seq_pc, ret_pc;
    res_t            cur, out, hold_d, hold_q;

    br_decode u_dec (
        .op   (instr[31:26]),
        .sub  (instr[20:16]),
        .kind (kind)
    );

    br_cond #(.W(XLEN)) u_cond (
        .kind (kind),
        .a    (rs_val),
        .b    (rt_val),
        .hit  (hit)
    );

    br_target #(.W(XLEN), .IW(IDX_W), .OW(OFF_W)) u_tgt (
        .pc         (pc),
        .idx        (instr[25:0]),
        .off        (instr[15:0]),
        .jump_tgt   (jump_tgt),
        .branch_tgt (branch_tgt),
        .seq_pc     (seq_pc),
        .ret_pc     (ret_pc)
    );

    always_comb begin
        cur           = '0;
        cur.target    = seq_pc;
        cur.link_data = '0;
        unique case (kind)
            K_J: begin
                cur.taken  = 1'b1;
                cur.target = jump_tgt;
            end
            K_JAL: begin
                cur.taken     = 1'b1;
                cur.target    = jump_tgt;
                cur.link_we   = 1'b1;
                cur.link_reg  = LINK_REG;
                cur.link_data = ret_pc;
            end
            K_BEQ, K_BNE, K_BLEZ, K_BGTZ, K_BLTZ, K_BGEZ: begin
                cur.taken  = hit;
                cur.target = branch_tgt;
            end
            K_BLTZAL, K_BGEZAL: begin
                cur.taken     = hit;
                cur.target    = branch_tgt;
                cur.link_we   = 1'b1;
                cur.link_reg  = LINK_REG;
                cur.link_data = ret_pc;
            end
            K_BAD: begin
                cur.trap = 1'b1;
            end
            default: ;
        endcase

        hold_d = in_valid ? cur : hold_q;
        out    = in_valid ? cur : hold_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign taken     = out.taken;
    assign target    = out.target;
    assign link_we   = out.link_we;
    assign link_reg  = out.link_reg;
    assign link_data = out.link_data;
    assign trap      = out.trap;
endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic [31:0] pc,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic        taken,
    input logic [31:0] target,
    input logic        link_we,
    input logic [4:0]  link_reg,
    input logic [31:0] link_data,
    input logic        trap
);
    // R8
    trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (!taken && !link_we));

    // R7
    link_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_reg == 5'd31));

    // R7
    link_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && link_we) |-> (link_data == pc + 32'd8));

    // R2
    jump_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (instr[31:26] == 6'd2 || instr[31:26] == 6'd3))
        |-> (taken && target == {pc[31:28], instr[25:0], 2'b00}));

    // R3
    branch_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (instr[31:26] >= 6'd4) && (instr[31:26] <= 6'd7))
        |-> (target == pc + 32'd4 + {{14{instr[15]}}, instr[15:0], 2'b00}));

    // R4
    beq_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:26] == 6'd4) |-> (taken == (rs_val == rt_val)));

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (in_valid || ($stable(taken) && $stable(target)
                       && $stable(link_we) && $stable(link_data) && $stable(trap))));
endmodule

bind branch_resolve branch_resolve_chk chk (.*);

// File: tb/branch_resolve_test.sv
module branch_resolve_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] instr, pc, rs_val, rt_val;
    logic        taken, link_we, trap;
    logic [31:0] target, link_data;
    logic [4:0]  link_reg;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    branch_resolve uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .pc(pc), .rs_val(rs_val), .rt_val(rt_val), .taken(taken),
        .target(target), .link_we(link_we), .link_reg(link_reg),
        .link_data(link_data), .trap(trap)
    );

    // reference results
    logic        e_tk, e_lw, e_tr;
    logic [31:0] e_tg, e_ld;
    logic [4:0]  e_lr;
    logic        h_tk, h_lw, h_tr;
    logic [31:0] h_tg, h_ld;
    logic [4:0]  h_lr;
    string       tag;

    task automatic model(input logic [31:0] i, input logic [31:0] p,
                         input logic [31:0] a, input logic [31:0] b);
        int op, sub;
        logic [31:0] btgt;
        op   = int'(i[31:26]);
        sub  = int'(i[20:16]);
        btgt = p + 32'd4 + (32'($signed(i[15:0])) << 2);
        e_tk = 0; e_lw = 0; e_tr = 0; e_lr = 0; e_ld = 0;
        e_tg = p + 32'd4;
        tag  = "R9";
        if (op == 2 || op == 3) begin
            e_tk = 1;
            e_tg = {p[31:28], i[25:0], 2'b00};
            tag  = "R2";
            if (op == 3) begin e_lw = 1; e_lr = 31; e_ld = p + 32'd8; tag = "R7"; end
        end else if (op == 4 || op == 5) begin
            e_tg = btgt;
            e_tk = (op == 4) ? (a == b) : (a != b);
            tag  = "R4";
        end else if (op == 6 || op == 7) begin
            e_tg = btgt;
            e_tk = (op == 6) ? ($signed(a) <= 0) : ($signed(a) > 0);
            tag  = "R5";
        end else if (op == 1) begin
            if (sub == 0 || sub == 1 || sub == 16 || sub == 17) begin
                e_tg = btgt;
                e_tk = (sub == 0 || sub == 16) ? ($signed(a) < 0) : ($signed(a) >= 0);
                tag  = "R6";
                if (sub >= 16) begin e_lw = 1; e_lr = 31; e_ld = p + 32'd8; tag = "R7"; end
            end else begin
                e_tr = 1;
                tag  = "R8";
            end
        end
    endtask

    task automatic cmp(input string t, input string f,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", t, f, act, exp);
        end
    endtask

    task automatic compare_all(input string t, input logic ek, input logic [31:0] eg,
                               input logic ew, input logic [4:0] er,
                               input logic [31:0] ed, input logic et);
        cmp(t, "taken", {31'b0, taken}, {31'b0, ek});
        cmp(t, "target", target, eg);
        cmp(t, "link_we", {31'b0, link_we}, {31'b0, ew});
        cmp(t, "link_reg", {27'b0, link_reg}, {27'b0, er});
        cmp(t, "link_data", link_data, ed);
        cmp(t, "trap", {31'b0, trap}, {31'b0, et});
        // R3: for defined branches the target is the offset form; also checked via model
    endtask

    // one clock: apply inputs after the edge, compare mid-cycle
    task automatic step(input logic v, input logic [31:0] i, input logic [31:0] p,
                        input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        #1;
        in_valid = v; instr = i; pc = p; rs_val = a; rt_val = b;
        #0.5;
        if (v) begin
            model(i, p, a, b);
            compare_all(tag, e_tk, e_tg, e_lw, e_lr, e_ld, e_tr);
            h_tk = e_tk; h_tg = e_tg; h_lw = e_lw; h_lr = e_lr; h_ld = e_ld; h_tr = e_tr;
        end else begin
            compare_all("R10", h_tk, h_tg, h_lw, h_lr, h_ld, h_tr);
        end
    endtask

    function automatic logic [31:0] mk(input int op, input int sub, input logic [15:0] off);
        return {6'(op), 5'd3, 5'(sub), off};
    endfunction

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 0; in_valid = 0; instr = 0; pc = 0; rs_val = 0; rt_val = 0;
        h_tk = 0; h_tg = 0; h_lw = 0; h_lr = 0; h_ld = 0; h_tr = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1 compare_all("R1", 0, 0, 0, 0, 0, 0);

        // R2 jumps across a region
        step(1, {6'd2, 26'h3ff_ffff}, 32'hA000_0010, 0, 0);
        step(1, {6'd3, 26'h000_0001}, 32'hF123_4560, 0, 0);
        // R4 equality in all bits
        step(1, mk(4, 0, 16'h0010), 32'h0000_1000, 32'h8000_0001, 32'h8000_0001);
        step(1, mk(4, 0, 16'h0010), 32'h0000_1000, 32'h8000_0001, 32'h0000_0001);
        step(1, mk(5, 0, 16'hFFFC), 32'h0000_2000, 32'h5, 32'h5);
        step(1, mk(5, 0, 16'hFFFC), 32'h0000_2000, 32'h5, 32'h4);
        // R5 sign and zero boundaries; R3 negative offset wrap
        step(1, mk(6, 0, 16'h8000), 32'h0000_0100, 32'h0, 0);
        step(1, mk(6, 0, 16'h8000), 32'h0000_0100, 32'h1, 0);
        step(1, mk(7, 0, 16'h7FFF), 32'hFFFF_FFF0, 32'h0, 0);
        step(1, mk(7, 0, 16'h7FFF), 32'hFFFF_FFF0, 32'h7FFF_FFFF, 0);
        step(1, mk(6, 0, 16'h0001), 32'h4, 32'h8000_0000, 0);
        // R6 and R7: linking sub-codes both taken and not taken
        for (int s = 0; s < 4; s++) begin
            int sc;
            sc = (s < 2) ? s : s + 14;
            step(1, mk(1, sc, 16'h0020), 32'h0040_0000, 32'hFFFF_FFFF, 0);
            step(1, mk(1, sc, 16'h0020), 32'h0040_0000, 32'h0, 0);
        end
        // R8 undefined sub-codes next to defined ones
        step(1, mk(1, 2, 16'h0020), 32'h0040_0000, 32'hFFFF_FFFF, 0);
        step(1, mk(1, 18, 16'h0020), 32'h0040_0000, 32'h0, 0);
        step(1, mk(1, 31, 16'h0020), 32'h0040_0000, 32'h0, 0);
        // R10 hold across idle cycles after a trap, then after a link
        step(0, 32'hFFFF_FFFF, 32'h1, 32'h2, 32'h3);
        step(0, mk(2, 0, 0), 32'h9, 32'h2, 32'h3);
        step(1, mk(1, 17, 16'h0004), 32'h0000_0800, 32'h1, 0);
        step(0, mk(3, 0, 0), 32'h77, 0, 0);
        // R9 non-control opcodes
        step(1, mk(0, 0, 16'h1234), 32'h0000_0300, 32'h1, 32'h1);
        step(1, mk(8, 16, 16'h1234), 32'h0000_0300, 32'h1, 32'h1);
        step(1, mk(43, 17, 16'h1234), 32'h0000_0300, 32'h1, 32'h1);
        // mixed sweep
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a, b, w;
            int op;
            a  = $urandom;
            b  = ($urandom_range(0, 3) == 0) ? a : $urandom;
            if ($urandom_range(0, 7) == 0) a = 0;
            op = $urandom_range(0, 9);
            w  = $urandom;
            w[31:26] = 6'(op);
            if (op == 1 && $urandom_range(0, 1) == 1) w[20:16] = 5'($urandom_range(0, 1) + 16 * $urandom_range(0, 1));
            step($urandom_range(0, 3) != 0, w, $urandom & 32'hFFFF_FFFC, a, b);
        end
        @(posedge clk);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule